// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block keeps the one-byte status register of a serial flash device and decides which modifying operations are allowed. A built-in SPI mode-0 slave takes commands: the host pulls chip select low, shifts in an 8-bit opcode, and then either gives an argument byte or reads status bytes back, most significant bit first. Every pin of the serial port and the write-protect pin is passed through a two-flop synchronizer into the system clock domain, so the serial clock has to be several system clocks slower than `clk`.

The register is made of four parts. The protect-level bits (three) and the lock bit model non-volatile storage and keep their value across `rst_n`. The write-enable latch must be set before any status write, program or erase. The busy flag is set while a status write or an array operation from the external engine is running. When the lock bit is set and the write-protect pin is low, the lock bit and the protect level are frozen. Two gating outputs tell the array engine whether a program or sector erase at `op_addr` may start, and whether a whole-array erase may start.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte is, from bit 7 to bit 0: lock bit, zero, zero, protect level (bits 4:2), write-enable latch (bit 1), busy (bit 0). Bits 6 and 5 always read 0.
- R2: After the opcode 0x05, the status byte is driven on `miso` on each falling serial-clock edge, MSB first, and is repeated as long as chip select stays low. Each repeat is loaded with the current value at its byte boundary. `miso_oe` is 0 while chip select is high.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly 8 bits.
- R4: Opcode 0x01 followed by one data byte, with chip select rising after exactly 16 bits, loads the lock bit from data bit 7 and the protect level from data bits 4:2. The latch must be 1, busy must be 0 and the device must not be frozen. Busy then reads 1 for `WRSR_CYC` clocks, and at the end the latch clears.
- R5: While the latch is 0, a status write changes nothing.
- R6: While the lock bit is 1 and `wp_n` is low, a status write is refused: the lock bit and protect level keep their values, and the latch clears.
- R7: While busy is 1, every command other than the status read is ignored. This includes the latch set, latch clear and status write.
- R8: `rst_n` clears the latch and the status-write timer. It keeps the lock bit and the protect level.
- R9: `area_wr_ok` is 1 exactly when the latch is 1, busy is 0 and `op_addr` is not covered. Protect level 0 covers nothing. Level k from 1 to 6 covers the top 1/2^(7-k) of the address space. Level 7 covers everything.
- R10: `bulk_erase_ok` is 1 exactly when the latch is 1, busy is 0 and the protect level is 0.
- R11: Busy follows `array_busy`. The falling edge of `array_busy` clears the latch.
- R12: A frame whose chip select rises off a byte boundary, or after a byte count other than the one the opcode requires, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; keeps the non-volatile bits |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso`; 0 means the pin floats |
| wp_n | input | 1 | Write-protect pin, active low |
| array_busy | input | 1 | High while the array engine runs a program or erase |
| op_addr | input | ADDR_W | Address of the pending program or sector erase |
| area_wr_ok | output | 1 | A program or sector erase at `op_addr` may start |
| bulk_erase_ok | output | 1 | A whole-array erase may start |

## Verification
A wrong latch or busy flag shows up on both gating outputs within three system clocks of the chip-select edge or `array_busy` edge that caused it. The bench model compares those outputs on every clock outside a short settling window. A corrupted lock bit or protect level may not move either gating output. It is found by the next status read, which echoes the whole byte twice in the same frame. A frozen-register bug shows up only when `wp_n` is low, so the bench writes the register in both pin states. It also resets between a write and a read-back, to prove that the non-volatile bits survive.

// File: rtl/fss_pkg.sv
// Package: shared opcodes and types for the flash status controller.
// Assumes: opcodes are one byte, and the status layout is fixed by the host protocol.
package fss_pkg;
    localparam logic [7:0] OPC_WRITE_STAT = 8'h01;
    localparam logic [7:0] OPC_LATCH_CLR  = 8'h04;
    localparam logic [7:0] OPC_READ_STAT  = 8'h05;
    localparam logic [7:0] OPC_LATCH_SET  = 8'h06;

    // Status byte; the field order is visible to the host
    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        logic [2:0] level;
        logic       wel;
        logic       busy;
    } stat_t;

    // Summary of a finished chip-select frame
    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] arg;
        logic [1:0] nbytes;   // whole bytes received, saturating at 3
        logic       aligned;  // no partial byte pending
    } frame_t;
endpackage

// File: rtl/fss_spi_port.sv
// Module: SPI mode-0 slave front end, oversampled by the system clock.
// Assumes: sck is at least 4 clk periods per phase; pins are asynchronous and
// synchronized here. It reports a frame summary when chip select rises.
module fss_spi_port
    import fss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] stat_in,
    output logic       miso,
    output logic       miso_oe,
    output logic       frame_end,
    output frame_t     frame
);
    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] sck_s, cs_s, mosi_s;
    logic       sck_d, cs_d;
    logic       sck_rise, sck_fall, cs_rise, sel;
    logic [2:0] bitpos;
    logic [1:0] nbytes;
    logic [7:0] rx_sh, opc_q, arg_q, tx_sh;
    logic       miso_q;

    // Bring the pins into the clk domain and keep their last values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
            sck_d  <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sck_s  <= {sck_s[SYNC_N-2:0], sck};
            cs_s   <= {cs_s[SYNC_N-2:0], cs_n};
            mosi_s <= {mosi_s[SYNC_N-2:0], mosi};
            sck_d  <= sck_s[SYNC_N-1];
            cs_d   <= cs_s[SYNC_N-1];
        end
    end

    assign sel      = ~cs_s[SYNC_N-1];
    assign sck_rise = sck_s[SYNC_N-1] & ~sck_d;
    assign sck_fall = ~sck_s[SYNC_N-1] & sck_d;
    assign cs_rise  = cs_s[SYNC_N-1] & ~cs_d;

    // Shift in host bits on rising sck; capture the opcode and argument bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitpos <= '0;
            nbytes <= '0;
            rx_sh  <= '0;
            opc_q  <= '0;
            arg_q  <= '0;
        end else if (!sel) begin
            bitpos <= '0;
            nbytes <= '0;
            opc_q  <= '0;
        end else if (sck_rise) begin
            rx_sh  <= {rx_sh[6:0], mosi_s[SYNC_N-1]};
            bitpos <= bitpos + 3'd1;
            if (bitpos == 3'd7) begin
                if (nbytes == 2'd0) opc_q <= {rx_sh[6:0], mosi_s[SYNC_N-1]};
                if (nbytes == 2'd1) arg_q <= {rx_sh[6:0], mosi_s[SYNC_N-1]};
                if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
            end
        end
    end

    // Drive status bits on falling sck after a read opcode; reload at each byte boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (!sel) begin
            miso_q <= 1'b0;
        end else if (sck_fall && nbytes != 2'd0 && opc_q == OPC_READ_STAT) begin
            if (bitpos == 3'd0) begin
                miso_q <= stat_in[7];
                tx_sh  <= {stat_in[6:0], 1'b0};
            end else begin
                miso_q <= tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    assign miso        = miso_q;
    assign miso_oe     = sel;
    assign frame_end   = cs_rise;
    assign frame.opc     = opc_q;
    assign frame.arg     = arg_q;
    assign frame.nbytes  = nbytes;
    assign frame.aligned = (bitpos == 3'd0);

    // R12: the bit position only moves on a sampled rising sck
    a_r12_bitpos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sck_rise && !$fell(sel)) |=> $stable(bitpos));
endmodule

// File: rtl/fss_stat_core.sv
// Module: status register state. Holds the non-volatile lock and protect level,
// the write-enable latch and the status-write busy timer.
// Assumes: array_busy and wp_n_s are synchronous to clk; frame is valid while frame_end is high.
module fss_stat_core
    import fss_pkg::*;
#(
    parameter int WRSR_CYC = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_end,
    input  frame_t frame,
    input  logic   wp_n_s,
    input  logic   array_busy,
    output stat_t  stat
);
    localparam int TW = $clog2(WRSR_CYC + 1);

    logic          lock_q  = 1'b0;
    logic [2:0]    level_q = 3'd0;
    logic          wel_q;
    logic          busy_d;
    logic [TW-1:0] timer_q;
    logic          wip, frozen, one_byte, two_byte;
    logic          do_set, do_clr, wr_hit, wr_take, wr_refuse;

    assign wip       = (timer_q != '0) | array_busy;
    assign frozen    = lock_q & ~wp_n_s;
    assign one_byte  = (frame.nbytes == 2'd1) & frame.aligned;
    assign two_byte  = (frame.nbytes == 2'd2) & frame.aligned;
    assign do_set    = frame_end & ~wip & one_byte & (frame.opc == OPC_LATCH_SET);
    assign do_clr    = frame_end & ~wip & one_byte & (frame.opc == OPC_LATCH_CLR);
    assign wr_hit    = frame_end & ~wip & two_byte & (frame.opc == OPC_WRITE_STAT) & wel_q;
    assign wr_take   = wr_hit & ~frozen;
    assign wr_refuse = wr_hit & frozen;

    // Non-volatile bits: no reset; loaded only by an accepted status write
    always_ff @(posedge clk) begin
        if (wr_take) begin
            lock_q  <= frame.arg[7];
            level_q <= frame.arg[4:2];
        end
    end

    // Count down the status-write cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        timer_q <= '0;
        else if (wr_take)  timer_q <= TW'(WRSR_CYC);
        else if (timer_q != '0) timer_q <= timer_q - TW'(1);
    end

    // Track the array engine's busy line to see its completion
    always_ff @(posedge clk) begin
        if (!rst_n) busy_d <= 1'b0;
        else        busy_d <= array_busy;
    end

    // Write-enable latch: set, clear, or drop when an operation ends or is refused
    always_ff @(posedge clk) begin
        if (!rst_n)                        wel_q <= 1'b0;
        else if (do_set)                   wel_q <= 1'b1;
        else if (do_clr || wr_refuse)      wel_q <= 1'b0;
        else if (timer_q == TW'(1))        wel_q <= 1'b0;
        else if (busy_d && !array_busy)    wel_q <= 1'b0;
    end

    assign stat.lock  = lock_q;
    assign stat.rsvd  = 2'b00;
    assign stat.level = level_q;
    assign stat.wel   = wel_q;
    assign stat.busy  = wip;

    // R5: the stored bits cannot change while the latch is clear
    a_r5_latch_guards: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_q |=> $stable({lock_q, level_q}));
    // R6: frozen mode keeps the stored bits
    a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wp_n_s) |=> $stable({lock_q, level_q}));
    // R7: nothing is written while busy
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> $stable({lock_q, level_q}));
    // R4: the latch is clear once the status-write cycle expires
    a_r4_latch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q == TW'(1)) |=> !wel_q);
    // R11: completion of an array operation clears the latch
    a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_d && !array_busy && !frame_end) |=> !wel_q);
endmodule

// File: rtl/fss_guard.sv
// Module: protection gate. Turns the protect level into a covered top fraction of
// the address space and combines it with the latch and busy flags.
// Assumes: ADDR_W >= 7 so that the smallest fraction, 1/64, is at least one address.
module fss_guard #(
    parameter int ADDR_W = 21
) (
    input  logic [2:0]        level,
    input  logic              wel,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    output logic              area_ok,
    output logic              bulk_ok
);
    logic [2:0]        span;
    logic [ADDR_W-1:0] top_mask;
    logic              covered;

    // Level k keeps the top (7-k) address bits; the address is covered if they are all ones
    always_comb begin
        span     = 3'd7 - level;
        top_mask = ~({ADDR_W{1'b1}} >> span);
        covered  = (level != 3'd0) && (&(addr | ~top_mask));
    end

    assign area_ok = wel & ~busy & ~covered;
    assign bulk_ok = wel & ~busy & (level == 3'd0);
endmodule

// File: rtl/flash_status_ctrl.sv
// Module: top level of the flash status and write-protection controller.
// Assumes: sck is slow against clk (at least 4 clk per phase); array_busy is synchronous to clk.
module flash_status_ctrl
    import fss_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int WRSR_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              wp_n,
    input  logic              array_busy,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              area_wr_ok,
    output logic              bulk_erase_ok
);
    logic [1:0] wp_s;
    logic       frame_end;
    frame_t     frame;
    stat_t      stat;

    // Synchronize the write-protect pin
    always_ff @(posedge clk) begin
        if (!rst_n) wp_s <= 2'b11;
        else        wp_s <= {wp_s[0], wp_n};
    end

    fss_spi_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .stat_in   (stat),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .frame_end (frame_end),
        .frame     (frame)
    );

    fss_stat_core #(.WRSR_CYC(WRSR_CYC)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .frame      (frame),
        .wp_n_s     (wp_s[1]),
        .array_busy (array_busy),
        .stat       (stat)
    );

    fss_guard #(.ADDR_W(ADDR_W)) u_guard (
        .level   (stat.level),
        .wel     (stat.wel),
        .busy    (stat.busy),
        .addr    (op_addr),
        .area_ok (area_wr_ok),
        .bulk_ok (bulk_erase_ok)
    );

    // R10: a bulk erase is only allowed when every address may be written
    a_r10_bulk_needs_area: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_erase_ok |-> area_wr_ok);
    // R2: the output stays disabled while chip select is high
    a_r2_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n && $past(cs_n, 2)) |-> !miso_oe);
endmodule

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;
    localparam int AW  = 21;
    localparam int CYC = 1000;
    localparam int H   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, array_busy = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic miso, miso_oe, area_wr_ok, bulk_erase_ok;

    int checks = 0, bad = 0;
    bit done = 0;

    // reference model state
    bit m_lock = 0;
    bit [2:0] m_level = 0;
    bit m_wel = 0;
    int m_timer = 0;
    bit m_busy = 0;
    int settle = 4;

    always #4 clk = ~clk;

    flash_status_ctrl #(.ADDR_W(AW), .WRSR_CYC(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .array_busy(array_busy),
        .op_addr(op_addr), .area_wr_ok(area_wr_ok), .bulk_erase_ok(bulk_erase_ok));

    function automatic bit m_wip();
        return (m_timer > 0) || m_busy;
    endfunction

    function automatic bit covered(logic [AW-1:0] a, bit [2:0] lv);
        longint size = longint'(1) << AW;
        if (lv == 0) return 0;
        if (lv == 7) return 1;
        return longint'(a) >= size - (size >> (7 - lv));
    endfunction

    function automatic logic [7:0] m_stat();
        return {m_lock, 2'b00, m_level, m_wel, m_wip()};
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_gates(string tag);
        bit ea = m_wel && !m_wip() && !covered(op_addr, m_level);
        bit eb = m_wel && !m_wip() && (m_level == 0);
        check(area_wr_ok === ea, {tag, " R9 area_wr_ok"}, area_wr_ok, ea);
        check(bulk_erase_ok === eb, {tag, " R10 bulk_erase_ok"}, bulk_erase_ok, eb);
    endtask

    // model timer and per-clock comparison of the gating outputs
    always @(negedge clk) begin
        if (m_timer > 0) begin
            m_timer--;
            if (m_timer == 0) begin
                m_wel = 0;
                settle = 6;
            end
        end
        if (settle > 0) settle--;
        else if (rst_n && !done) compare_gates("clk");
    end

    // model effect of a finished frame
    task automatic model_frame(logic [7:0] opc, logic [7:0] arg, int n);
        if (m_wip()) return;
        if (n == 8 && opc == 8'h06) m_wel = 1;
        if (n == 8 && opc == 8'h04) m_wel = 0;
        if (n == 16 && opc == 8'h01 && m_wel) begin
            if (m_lock && !wp_n) m_wel = 0;
            else begin
                m_lock = arg[7];
                m_level = arg[4:2];
                m_timer = CYC;
            end
        end
    endtask

    task automatic xfer(input logic [23:0] d, input int n, output logic [15:0] rd);
        rd = '0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = d[n-1-i];
            repeat (H) @(negedge clk);
            if (i >= 8) rd = {rd[14:0], miso};
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        model_frame(d[n-1 -: 8], (n >= 16) ? d[n-9 -: 8] : 8'h00, n);
        settle = 6;
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd(logic [7:0] opc);
        logic [15:0] rd;
        xfer({16'h0, opc}, 8, rd);
    endtask

    task automatic wrsr(logic [7:0] v);
        logic [15:0] rd;
        xfer({8'h0, 8'h01, v}, 16, rd);
    endtask

    task automatic read_stat(string tag);
        logic [15:0] rd;
        logic [7:0] e;
        e = m_stat();
        xfer(24'h050000, 24, rd);
        check(rd[15:8] === e, {tag, " first byte"}, rd[15:8], e);
        check(rd[7:0] === e, {tag, " repeated byte"}, rd[7:0], e);
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        longint size = longint'(1) << AW;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(6);
        // R8 reset state, R2 idle output
        check(miso_oe === 1'b0, "R2 oe idle", miso_oe, 0);
        check(area_wr_ok === 1'b0, "R8 latch clear after reset", area_wr_ok, 0);
        read_stat("R1 R8 reset status");

        // R3 set and clear the latch
        cmd(8'h06);
        read_stat("R3 latch set");
        op_addr = AW'(size - 1);
        wait_clk(2);
        check(bulk_erase_ok === 1'b1, "R10 level 0 bulk allowed", bulk_erase_ok, 1);
        cmd(8'h04);
        read_stat("R3 latch clear");

        // R12 off-boundary and wrong-length frames
        xfer({15'h0, 8'h06, 1'b1}, 9, rd);
        read_stat("R12 nine bits ignored");
        xfer({8'h0, 8'h06, 8'h00}, 16, rd);
        read_stat("R12 two bytes ignored");

        // R5 write without latch
        wrsr(8'h0C);
        read_stat("R5 write without latch");

        // R4 accepted write, R7 busy ignores commands
        cmd(8'h06);
        wrsr(8'h0C);
        read_stat("R4 R7 busy after write");
        cmd(8'h04);
        read_stat("R7 latch clear ignored while busy");
        wait_clk(CYC + 20);
        read_stat("R4 write done latch cleared");

        // R9 coverage at level 3 (top 1/16)
        cmd(8'h06);
        op_addr = AW'(size - (size >> 4));
        wait_clk(2);
        check(area_wr_ok === 1'b0, "R9 boundary covered", area_wr_ok, 0);
        op_addr = AW'(size - (size >> 4) - 1);
        wait_clk(2);
        check(area_wr_ok === 1'b1, "R9 below boundary open", area_wr_ok, 1);
        check(bulk_erase_ok === 1'b0, "R10 level nonzero blocks bulk", bulk_erase_ok, 0);

        // R11 array engine busy and completion
        array_busy = 1'b1; m_busy = 1; settle = 5;
        wait_clk(8);
        read_stat("R11 busy follows engine");
        array_busy = 1'b0; m_busy = 0; m_wel = 0; settle = 5;
        wait_clk(8);
        read_stat("R11 completion clears latch");

        // R9 sweep of all levels at their boundaries
        for (int lv = 0; lv < 8; lv++) begin
            cmd(8'h06);
            wrsr(8'(lv << 2));
            wait_clk(CYC + 20);
            cmd(8'h06);
            if (lv >= 1 && lv <= 6) begin
                op_addr = AW'(size - (size >> (7 - lv)));
                wait_clk(2);
                compare_gates("R9 sweep edge");
                op_addr = AW'(size - (size >> (7 - lv)) - 1);
                wait_clk(2);
                compare_gates("R9 sweep below");
            end else begin
                op_addr = '0;
                wait_clk(2);
                compare_gates("R9 sweep low addr");
            end
        end

        // R8 non-volatile bits survive reset
        cmd(8'h06);
        wrsr(8'h9C);
        wait_clk(CYC + 20);
        rst_n = 1'b0; settle = 6;
        wait_clk(4);
        m_wel = 0; m_timer = 0;
        rst_n = 1'b1;
        wait_clk(6);
        read_stat("R8 lock and level kept over reset");

        // R6 frozen mode refuses the write and drops the latch
        wp_n = 1'b0; settle = 5;
        wait_clk(6);
        cmd(8'h06);
        wrsr(8'h00);
        read_stat("R6 frozen write refused");
        wp_n = 1'b1; settle = 5;
        wait_clk(6);
        cmd(8'h06);
        wrsr(8'h00);
        wait_clk(CYC + 20);
        read_stat("R6 unfrozen write accepted");

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule